// File: doc/BRIEF.md
# Transceiver Automatic Mode Controller

This block is the mode sequencer of a radio transceiver. A host writes a 5-bit command into a command register to choose a state. There are two plain states, receive-listen and transmit-ready, plus an off state. There are also two automatic states. In the first, receive frames are acknowledged without host help. In the second, transmit frames are sent with channel-access retries. The host reads a 5-bit status field to see where the controller stands. That field shows a separate code for the idle and busy sub-states of every mode, and a transition code while a change is in progress.

The controller drives enable lines that hand the channel to the receive and transmit engines. It watches their busy and done strobes to follow each frame. It refuses to enter either automatic mode unless the automatic-CRC configuration bit is set. A new command never cuts a frame short. A command that arrives while a frame is in flight, or while a change is in progress, is held. Once the controller is settled again, the command is applied.

Top module: `trx_mode_ctrl`

## Requirements
- R1: After reset the status reads 8 (off), the configuration bit reads 0, and rx_en, tx_en, auto_ack_en and auto_retry_en are all low.
- R2: A register write to address 2 takes bits [4:0] as a command. The codes are 8 off, 6 receive, 9 transmit, 22 auto-acknowledge receive and 25 auto-retry transmit. An accepted command ends, after the transition, with the status equal to its own code. Code 0 and every other value are ignored and leave the status unchanged.
- R3: A read of address 1 returns the status in bits [4:0], with bits [7:5] zero. The idle codes equal the command codes. The busy codes are 1 for receive, 2 for transmit, 17 for auto-acknowledge and 18 for auto-retry. The transition code is 31.
- R4: After a command is accepted, the status reads 31 for exactly TRANS_CYC cycles (default 4). All four enable outputs stay low during that time.
- R5: While bit 0 of address 5 is 0, commands 22 and 25 are ignored and the status stays where it was.
- R6: In an idle sub-state of the receive family, an rx_busy strobe turns the status into the matching busy code on the next cycle. An rx_done strobe turns it back to the idle code. The transmit family does the same with tx_busy and tx_done.
- R7: A busy code holds until the matching done strobe. A command written during a busy sub-state or a transition is held, and a later write replaces it. The held command is applied in the first cycle the controller is settled again.
- R8: Any other valid command leaves an automatic mode, including a move straight from one automatic mode to the other. A command naming the current mode has no effect.
- R9: rx_en is high in the receive and auto-acknowledge states. tx_en is high in the transmit and auto-retry states. auto_ack_en and auto_retry_en mark the automatic ones. rx_en and tx_en are never high together.
- R10: A read of address 5 returns the configuration bit in bit 0. A read of any address other than 1 or 5 returns zero.
- R11: If a busy strobe and a command write land in the same idle cycle, the busy strobe wins and the command is held as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | DATA_W | Register read data |
| rx_busy | input | 1 | Receive engine has started a frame |
| rx_done | input | 1 | Receive engine has finished a frame |
| tx_busy | input | 1 | Transmit engine has started a frame |
| tx_done | input | 1 | Transmit engine has finished a frame |
| rx_en | output | 1 | Receive engine enabled |
| tx_en | output | 1 | Transmit engine enabled |
| auto_ack_en | output | 1 | Automatic acknowledge active |
| auto_retry_en | output | 1 | Automatic retry active |

## Verification
The bench targets commands that land at awkward moments:
- A command written during a frame would, in a wrong design, drop the frame early or be lost.
- Two writes during one frame check that the latest command wins. A design that kept the first would settle in the wrong mode.
- A busy strobe that coincides with a write checks that the frame is not skipped.
- A command written mid-transition checks that the first change finishes and the second follows it.

Automatic commands are sent with the CRC bit clear; a design that failed to gate them would show the transition code. The bench also exits an automatic mode straight into the other one, and repeats the current command; a wrong design would either stay put or restart a transition.

// File: rtl/trxmode_pkg.sv
package trxmode_pkg;

   localparam int CODE_W = 5;
   typedef logic [CODE_W-1:0] code_t;

   typedef enum logic [3:0] {
      M_IDLE, M_RX, M_RX_BSY, M_TX, M_TX_BSY,
      M_AAR, M_AAR_BSY, M_ART, M_ART_BSY, M_CHG
   } mode_t;

   // command codes (the idle status codes reuse them)
   localparam code_t C_NOP  = 5'd0;
   localparam code_t C_OFF  = 5'd8;
   localparam code_t C_RX   = 5'd6;
   localparam code_t C_TX   = 5'd9;
   localparam code_t C_AAR  = 5'd22;
   localparam code_t C_ART  = 5'd25;
   // status-only codes
   localparam code_t S_RX_BSY  = 5'd1;
   localparam code_t S_TX_BSY  = 5'd2;
   localparam code_t S_AAR_BSY = 5'd17;
   localparam code_t S_ART_BSY = 5'd18;
   localparam code_t S_CHG     = 5'd31;

   function automatic logic code_is_cmd(code_t c);
      return (c == C_OFF) || (c == C_RX) || (c == C_TX) ||
             (c == C_AAR) || (c == C_ART);
   endfunction

   function automatic mode_t cmd_to_mode(code_t c);
      case (c)
         C_RX:    return M_RX;
         C_TX:    return M_TX;
         C_AAR:   return M_AAR;
         C_ART:   return M_ART;
         default: return M_IDLE;
      endcase
   endfunction

   function automatic code_t mode_code(mode_t m);
      case (m)
         M_RX:      return C_RX;
         M_RX_BSY:  return S_RX_BSY;
         M_TX:      return C_TX;
         M_TX_BSY:  return S_TX_BSY;
         M_AAR:     return C_AAR;
         M_AAR_BSY: return S_AAR_BSY;
         M_ART:     return C_ART;
         M_ART_BSY: return S_ART_BSY;
         M_CHG:     return S_CHG;
         default:   return C_OFF;
      endcase
   endfunction

   function automatic logic mode_is_busy(mode_t m);
      return (m == M_RX_BSY) || (m == M_TX_BSY) ||
             (m == M_AAR_BSY) || (m == M_ART_BSY);
   endfunction

   function automatic logic mode_is_auto(mode_t m);
      return (m == M_AAR) || (m == M_AAR_BSY) ||
             (m == M_ART) || (m == M_ART_BSY);
   endfunction

   function automatic logic rx_family(mode_t m);
      return (m == M_RX) || (m == M_RX_BSY) ||
             (m == M_AAR) || (m == M_AAR_BSY);
   endfunction

   function automatic logic tx_family(mode_t m);
      return (m == M_TX) || (m == M_TX_BSY) ||
             (m == M_ART) || (m == M_ART_BSY);
   endfunction

   function automatic mode_t busy_of(mode_t m);
      case (m)
         M_RX:    return M_RX_BSY;
         M_TX:    return M_TX_BSY;
         M_AAR:   return M_AAR_BSY;
         M_ART:   return M_ART_BSY;
         default: return m;
      endcase
   endfunction

   function automatic mode_t idle_of(mode_t m);
      case (m)
         M_RX_BSY:  return M_RX;
         M_TX_BSY:  return M_TX;
         M_AAR_BSY: return M_AAR;
         M_ART_BSY: return M_ART;
         default:   return m;
      endcase
   endfunction

endpackage

// File: rtl/trxmode_regs.sv
// Command capture, held-command slot and configuration bit.
module trxmode_regs
   import trxmode_pkg::*;
#(
   parameter int ADDR_W   = 6,
   parameter int DATA_W   = 8,
   parameter int CMD_ADDR = 2,
   parameter int CFG_ADDR = 5,
   parameter int CRC_BIT  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              take,
   output logic              crc_on,
   output logic              eff_valid,
   output code_t             eff_cmd
);

   localparam logic [ADDR_W-1:0] CMD_A = ADDR_W'(CMD_ADDR);
   localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(CFG_ADDR);

   logic  wr_cmd;
   code_t wr_code;
   logic  held_v;
   code_t held_c;
   logic  unused_wr_bits;

   assign wr_code        = wr_data[CODE_W-1:0];
   assign wr_cmd         = wr_en && (wr_addr == CMD_A) && code_is_cmd(wr_code);
   assign unused_wr_bits = ^wr_data;

   // newest command wins over a held one
   assign eff_valid = wr_cmd || held_v;
   assign eff_cmd   = wr_cmd ? wr_code : held_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_on <= 1'b0;
      end else if (wr_en && (wr_addr == CFG_A)) begin
         crc_on <= wr_data[CRC_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_v <= 1'b0;
         held_c <= C_NOP;
      end else if (take) begin
         held_v <= 1'b0;
      end else if (wr_cmd) begin
         held_v <= 1'b1;
         held_c <= wr_code;
      end
   end

endmodule

// File: rtl/trxmode_fsm.sv
// Mode state machine with transition timer and frame tracking.
module trxmode_fsm
   import trxmode_pkg::*;
#(
   parameter int TRANS_CYC = 4
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  eff_valid,
   input  code_t eff_cmd,
   input  logic  crc_on,
   input  logic  rx_busy,
   input  logic  rx_done,
   input  logic  tx_busy,
   input  logic  tx_done,
   output mode_t mode,
   output logic  take
);

   localparam bit HAS_CHG = (TRANS_CYC > 0);
   localparam int TW      = (TRANS_CYC > 1) ? $clog2(TRANS_CYC) : 1;
   localparam logic [TW-1:0] TMR_INIT = TW'((TRANS_CYC > 0) ? TRANS_CYC - 1 : 0);

   mode_t         cur;
   mode_t         tgt;
   mode_t         req;
   logic [TW-1:0] tmr;
   logic          settled;
   logic          busy_hit;
   logic          done_hit;
   logic          accept;

   assign settled  = (cur != M_CHG) && !mode_is_busy(cur);
   assign busy_hit = settled && ((rx_family(cur) && rx_busy) ||
                                 (tx_family(cur) && tx_busy));
   assign done_hit = mode_is_busy(cur) && ((rx_family(cur) && rx_done) ||
                                           (tx_family(cur) && tx_done));
   assign take     = settled && !busy_hit && eff_valid;
   assign req      = cmd_to_mode(eff_cmd);
   assign accept   = take && (req != cur) && (!mode_is_auto(req) || crc_on);
   assign mode     = cur;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur <= M_IDLE;
         tgt <= M_IDLE;
         tmr <= '0;
      end else if (cur == M_CHG) begin
         if (tmr == '0) cur <= tgt;
         else           tmr <= tmr - TW'(1);
      end else if (done_hit) begin
         cur <= idle_of(cur);
      end else if (busy_hit) begin
         cur <= busy_of(cur);
      end else if (accept) begin
         if (HAS_CHG) begin
            cur <= M_CHG;
            tgt <= req;
            tmr <= TMR_INIT;
         end else begin
            cur <= req;
         end
      end
   end

endmodule

// File: rtl/trxmode_decode.sv
// Status encoding, read mux and engine enables.
module trxmode_decode
   import trxmode_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int DATA_W    = 8,
   parameter int STAT_ADDR = 1,
   parameter int CFG_ADDR  = 5,
   parameter int CRC_BIT   = 0,
   parameter bit READ_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  mode_t             mode,
   input  logic              crc_on,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              rx_en,
   output logic              tx_en,
   output logic              auto_ack_en,
   output logic              auto_retry_en
);

   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
   localparam logic [ADDR_W-1:0] CFG_A  = ADDR_W'(CFG_ADDR);

   logic [DATA_W-1:0] rd_next;

   always_comb begin
      rd_next = '0;
      if (rd_addr == STAT_A) begin
         rd_next[CODE_W-1:0] = mode_code(mode);
      end else if (rd_addr == CFG_A) begin
         rd_next[CRC_BIT] = crc_on;
      end
   end

   generate
      if (READ_REG) begin : g_rd_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rd_data <= '0;
            else        rd_data <= rd_next;
         end
      end else begin : g_rd_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign rd_data    = rd_next;
      end
   endgenerate

   assign rx_en         = rx_family(mode);
   assign tx_en         = tx_family(mode);
   assign auto_ack_en   = (mode == M_AAR) || (mode == M_AAR_BSY);
   assign auto_retry_en = (mode == M_ART) || (mode == M_ART_BSY);

endmodule

// File: rtl/trx_mode_ctrl.sv
module trx_mode_ctrl
   import trxmode_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int DATA_W    = 8,
   parameter int STAT_ADDR = 1,
   parameter int CMD_ADDR  = 2,
   parameter int CFG_ADDR  = 5,
   parameter int CRC_BIT   = 0,
   parameter int TRANS_CYC = 4,
   parameter bit READ_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              rx_busy,
   input  logic              rx_done,
   input  logic              tx_busy,
   input  logic              tx_done,
   output logic              rx_en,
   output logic              tx_en,
   output logic              auto_ack_en,
   output logic              auto_retry_en
);

   generate
      if (DATA_W < CODE_W) begin : g_bad_dw
         $error("DATA_W must hold a command code");
      end
      if (CRC_BIT < 0 || CRC_BIT >= DATA_W) begin : g_bad_crc
         $error("CRC_BIT out of range");
      end
      if (STAT_ADDR == CMD_ADDR || STAT_ADDR == CFG_ADDR || CMD_ADDR == CFG_ADDR) begin : g_bad_map
         $error("register addresses must differ");
      end
      if (CFG_ADDR >= (1 << ADDR_W) || CMD_ADDR >= (1 << ADDR_W) ||
          STAT_ADDR >= (1 << ADDR_W)) begin : g_bad_aw
         $error("address does not fit ADDR_W");
      end
      if (TRANS_CYC < 0) begin : g_bad_tc
         $error("TRANS_CYC must not be negative");
      end
   endgenerate

   logic  crc_on;
   logic  eff_valid;
   code_t eff_cmd;
   logic  take_w;
   mode_t mode_q;

   trxmode_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_ADDR(CMD_ADDR),
      .CFG_ADDR(CFG_ADDR), .CRC_BIT(CRC_BIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .take(take_w), .crc_on(crc_on),
      .eff_valid(eff_valid), .eff_cmd(eff_cmd)
   );

   trxmode_fsm #(.TRANS_CYC(TRANS_CYC)) u_fsm (
      .clk(clk), .rst_n(rst_n), .eff_valid(eff_valid), .eff_cmd(eff_cmd),
      .crc_on(crc_on), .rx_busy(rx_busy), .rx_done(rx_done),
      .tx_busy(tx_busy), .tx_done(tx_done), .mode(mode_q), .take(take_w)
   );

   trxmode_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_ADDR(STAT_ADDR),
      .CFG_ADDR(CFG_ADDR), .CRC_BIT(CRC_BIT), .READ_REG(READ_REG)
   ) u_dec (
      .clk(clk), .rst_n(rst_n), .mode(mode_q), .crc_on(crc_on),
      .rd_addr(rd_addr), .rd_data(rd_data), .rx_en(rx_en), .tx_en(tx_en),
      .auto_ack_en(auto_ack_en), .auto_retry_en(auto_retry_en)
   );

endmodule

// File: rtl/trx_mode_ctrl_chk.sv
module trx_mode_ctrl_chk
   import trxmode_pkg::*;
#(
   parameter int TRANS_CYC = 4
) (
   input logic  clk,
   input logic  rst_n,
   input mode_t mode,
   input logic  rx_busy,
   input logic  rx_done,
   input logic  tx_done,
   input logic  rx_en,
   input logic  tx_en,
   input logic  auto_ack_en,
   input logic  auto_retry_en
);

   int chg_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              chg_run <= 0;
      else if (mode == M_CHG)  chg_run <= chg_run + 1;
      else                     chg_run <= 0;
   end

   AST_CHG_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n) (mode == M_CHG) |-> (chg_run < TRANS_CYC)); // R4
   AST_CHG_ENDS: assert property (@(posedge clk) disable iff (!rst_n) (mode == M_CHG && chg_run == TRANS_CYC - 1) |=> (mode != M_CHG)); // R4
   AST_CHG_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (mode == M_CHG) |-> !(rx_en || tx_en || auto_ack_en || auto_retry_en)); // R4
   AST_EN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({rx_en, tx_en})); // R9
   AST_AUTO_ACK_RX: assert property (@(posedge clk) disable iff (!rst_n) auto_ack_en |-> rx_en); // R9
   AST_AUTO_RETRY_TX: assert property (@(posedge clk) disable iff (!rst_n) auto_retry_en |-> tx_en); // R9
   AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (mode == M_AAR_BSY && !rx_done) |=> (mode == M_AAR_BSY)); // R7
   AST_BUSY_RETURN: assert property (@(posedge clk) disable iff (!rst_n) (mode == M_ART_BSY && tx_done) |=> (mode == M_ART)); // R6
   AST_BUSY_WINS: assert property (@(posedge clk) disable iff (!rst_n) (mode == M_RX && rx_busy) |=> (mode == M_RX_BSY)); // R11

endmodule

bind trx_mode_ctrl trx_mode_ctrl_chk #(.TRANS_CYC(TRANS_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .mode(mode_q), .rx_busy(rx_busy),
   .rx_done(rx_done), .tx_done(tx_done), .rx_en(rx_en), .tx_en(tx_en),
   .auto_ack_en(auto_ack_en), .auto_retry_en(auto_retry_en)
);

// File: tb/trx_mode_ctrl_test.sv
module trx_mode_ctrl_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [5:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [5:0] rd_addr = 6'd1;
   logic [7:0] rd_data;
   logic       rx_busy = 1'b0, rx_done = 1'b0, tx_busy = 1'b0, tx_done = 1'b0;
   logic       rx_en, tx_en, auto_ack_en, auto_retry_en;

   int n_run  = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   logic [4:0] q_code[$];
   string      q_tag[$];

   always #5 clk = ~clk;

   trx_mode_ctrl uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .rx_busy(rx_busy), .rx_done(rx_done), .tx_busy(tx_busy),
      .tx_done(tx_done), .rx_en(rx_en), .tx_en(tx_en),
      .auto_ack_en(auto_ack_en), .auto_retry_en(auto_retry_en)
   );

   task automatic check(string tag, int act, int exp_v);
      n_run++;
      if (act != exp_v) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
      end
   endtask

   // driver side: queue expected status, one entry per following negedge
   task automatic expect_st(int code, int n, string tag);
      for (int i = 0; i < n; i++) begin
         q_code.push_back(5'(code));
         q_tag.push_back(tag);
      end
   endtask

   task automatic drain();
      wait (q_code.size() == 0);
      @(negedge clk);
   endtask

   task automatic reg_write(int addr, int data);
      wr_en   = 1'b1;
      wr_addr = 6'(addr);
      wr_data = 8'(data);
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   // which: 0 rx_busy, 1 rx_done, 2 tx_busy, 3 tx_done
   task automatic strobe(int which);
      case (which)
         0: rx_busy = 1'b1;
         1: rx_done = 1'b1;
         2: tx_busy = 1'b1;
         default: tx_done = 1'b1;
      endcase
      @(negedge clk);
      rx_busy = 1'b0; rx_done = 1'b0; tx_busy = 1'b0; tx_done = 1'b0;
   endtask

   // monitor: compares status readback against the scoreboard queue
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (q_code.size() > 0) begin
            logic [4:0] e;
            string      t;
            e = q_code.pop_front();
            t = q_tag.pop_front();
            check(t, int'(rd_data[4:0]), int'(e));
            check(t, int'(rd_data[7:5]), 0);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog (all requirements): actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1", int'(rd_data), 8);
      check("R1", int'({rx_en, tx_en, auto_ack_en, auto_retry_en}), 0);
      rd_addr = 6'd5; #1;
      check("R1", int'(rd_data), 0);
      rd_addr = 6'd1;
      @(negedge clk);

      // R5 automatic commands refused with CRC bit clear
      reg_write(2, 22); expect_st(8, 3, "R5"); drain();
      reg_write(2, 25); expect_st(8, 2, "R5"); drain();
      // R2 unknown and zero codes ignored
      reg_write(2, 13); expect_st(8, 2, "R2"); drain();
      reg_write(2, 0);  expect_st(8, 2, "R2"); drain();

      // R2 / R4 plain receive
      reg_write(2, 6);
      expect_st(31, 1, "R4");
      #1 check("R4", int'({rx_en, tx_en, auto_ack_en, auto_retry_en}), 0);
      expect_st(31, 3, "R4");
      expect_st(6, 1, "R2");
      drain();
      check("R9", int'({rx_en, tx_en, auto_ack_en, auto_retry_en}), 4'b1000);

      // R6 / R3 busy in receive, R7 command held during frame
      strobe(0);
      expect_st(1, 1, "R3");
      reg_write(2, 9);
      expect_st(1, 2, "R7");
      @(negedge clk);
      strobe(1);
      expect_st(6, 1, "R6");
      expect_st(31, 4, "R7");
      expect_st(9, 1, "R7");
      drain();

      // R8 same command has no effect
      reg_write(2, 9); expect_st(9, 2, "R8"); drain();

      // enable CRC, R10 readback
      reg_write(5, 1); expect_st(9, 1, "R10"); drain();
      rd_addr = 6'd5; #1;
      check("R10", int'(rd_data), 1);
      rd_addr = 6'd2; #1;
      check("R10", int'(rd_data), 0);
      rd_addr = 6'd1;
      @(negedge clk);

      // auto-retry transmit
      reg_write(2, 25);
      expect_st(31, 4, "R4");
      expect_st(25, 1, "R2");
      drain();
      check("R9", int'({rx_en, tx_en, auto_ack_en, auto_retry_en}), 4'b0101);

      // R6 transmit busy and return
      strobe(2);
      expect_st(18, 1, "R6");
      strobe(3);
      expect_st(25, 1, "R6");
      drain();

      // R8 straight from one automatic mode to the other
      reg_write(2, 22);
      expect_st(31, 4, "R8");
      expect_st(22, 1, "R8");
      drain();
      check("R8", int'({rx_en, tx_en, auto_ack_en, auto_retry_en}), 4'b1010);

      // R11 busy and command in same cycle; R7 latest command wins
      rx_busy = 1'b1;
      reg_write(2, 6);
      rx_busy = 1'b0;
      expect_st(17, 1, "R11");
      reg_write(2, 8);
      expect_st(17, 1, "R7");
      strobe(1);
      expect_st(22, 1, "R7");
      expect_st(31, 4, "R7");
      expect_st(8, 1, "R8");
      drain();

      // R7 command written during a transition
      reg_write(2, 6);
      expect_st(31, 1, "R7");
      reg_write(2, 9);
      expect_st(31, 3, "R7");
      expect_st(6, 1, "R7");
      expect_st(31, 4, "R7");
      expect_st(9, 1, "R7");
      drain();
      check("R9", int'({rx_en, tx_en, auto_ack_en, auto_retry_en}), 4'b0100);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule